// File: doc/BRIEF.md
# Eight-Way Interrupt Priority Restart Opcode Generator

This block lets eight peripheral request lines share the single maskable interrupt input of a small processor. It picks the highest-numbered active request, raises the interrupt line toward the processor, and when the processor answers with its acknowledge strobe it drives onto the data bus a one-byte restart opcode. That opcode carries the winning index in a three-bit field; every other bit is one.

Alongside the opcode it reports the winning index, a flag that some request is present, and the call address the restart opcode leads to. The winner is frozen on the first clock edge of the acknowledge. A request that arrives later, even a more urgent one, cannot alter the byte the processor is reading. The interrupt line drops the moment acknowledge is seen, so the same request does not re-enter by itself when the processor later re-enables interrupts.

Top module: `irq_restart_encoder`

## Requirements
- R1: With acknowledge low, `sel_idx_o` equals the highest bit position set in `req_i` (position 7 beats all others, position 0 is lowest), and it is 0 when no bit is set.
- R2: `valid_o` is 1 exactly when at least one bit of `req_i` is set, in the same cycle.
- R3: With acknowledge low, `intr_o` is 1 exactly when at least one request bit is set.
- R4: `intr_o` is 0 in every cycle in which `ack_i` is 1, whatever the requests.
- R5: `bus_oe_o` equals `ack_i`, and `bus_data_o` is 8'h00 whenever `ack_i` is 0.
- R6: While `ack_i` is 1, `bus_data_o` is 8'hC7 OR (index shifted left by 3): bits 7:6 and 2:0 are all ones and bits 5:3 hold the index shown on `sel_idx_o`.
- R7: `call_addr_o` is the 16-bit value `sel_idx_o` × 8, so index 0 gives 16'h0000 and index 7 gives 16'h0038.
- R8: The index shown in the first cycle of an acknowledge is captured on that cycle's clock edge and held on `sel_idx_o`, `call_addr_o` and `bus_data_o` until `ack_i` falls, even if the requests change in between, including to all ones or all zeros.
- R9: In the cycle `ack_i` falls, the outputs again follow the live requests, with no cycle of delay.
- R10: While `rst_n` is 0 with no requests and no acknowledge, `intr_o`, `valid_o`, `bus_oe_o`, `sel_idx_o`, `call_addr_o` and `bus_data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Request lines, one per device, active high |
| ack_i | input | 1 | Interrupt acknowledge from the processor, active high |
| intr_o | output | 1 | Interrupt request to the processor |
| valid_o | output | 1 | At least one request is active |
| sel_idx_o | output | 3 | Winning (or held) request index |
| call_addr_o | output | 16 | Call address of the selected restart, index × 8 |
| bus_oe_o | output | 1 | Data-bus drive enable |
| bus_data_o | output | 8 | Restart opcode during acknowledge, zero otherwise |

## Verification
The hardest situation to reach from the ports is a change in the requests in the middle of an acknowledge. A more urgent request turning up then must leave the byte on the bus unchanged. For every one of the 256 request patterns, the bench opens an acknowledge and checks the live opcode. It then replaces the requests with all ones on the next cycle and checks that the opcode, index and address keep the captured winner. After that it drops acknowledge and checks that index 7 shows at once. A separate pass clears every request mid-acknowledge to confirm the hold does not depend on the requester staying present.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

   localparam int unsigned OPC_W     = 8;
   localparam int unsigned FIELD_W   = 3;
   localparam int unsigned FIELD_LSB = 3;
   localparam logic [OPC_W-1:0] OPC_BASE = 8'hC7;

   typedef enum int unsigned {
      ENC_SCAN   = 0,
      ENC_ONEHOT = 1
   } enc_arch_e;

   function automatic logic [OPC_W-1:0] pack_restart(input logic [FIELD_W-1:0] fld);
      logic [OPC_W-1:0] shifted;
      shifted = OPC_W'(fld) << FIELD_LSB;
      return OPC_BASE | shifted;
   endfunction

endpackage

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc #(
   parameter int unsigned NUM_REQ  = 8,
   parameter int unsigned IDX_W    = $clog2(NUM_REQ),
   parameter int unsigned ENC_ARCH = 0
) (
   input  logic [NUM_REQ-1:0] req_i,
   output logic [IDX_W-1:0]   idx_o,
   output logic               any_o
);
   import irqv_pkg::*;

   assign any_o = |req_i;

   generate
      if (ENC_ARCH == ENC_SCAN) begin : g_scan
         always_comb begin
            idx_o = '0;
            for (int i = 0; i < NUM_REQ; i++) begin
               if (req_i[i]) idx_o = IDX_W'(i);
            end
         end
      end else begin : g_onehot
         logic [NUM_REQ-1:0] above;
         logic [NUM_REQ-1:0] win_oh;

         assign above[NUM_REQ-1] = 1'b0;
         for (genvar g = 0; g < NUM_REQ - 1; g++) begin : g_chain
            assign above[g] = above[g+1] | req_i[g+1];
         end
         assign win_oh = req_i & ~above;

         always_comb begin
            idx_o = '0;
            for (int b = 0; b < IDX_W; b++) begin
               for (int i = 0; i < NUM_REQ; i++) begin
                  if (((i >> b) & 1) == 1) idx_o[b] = idx_o[b] | win_oh[i];
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/irqv_ack_hold.sv
module irqv_ack_hold #(
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_i,
   input  logic [IDX_W-1:0] live_idx_i,
   output logic [IDX_W-1:0] cur_idx_o
);
   logic             ack_q;
   logic [IDX_W-1:0] held_idx;
   logic             ack_start;

   assign ack_start = ack_i & ~ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q    <= 1'b0;
         held_idx <= '0;
      end else begin
         ack_q <= ack_i;
         if (ack_start) held_idx <= live_idx_i;
      end
   end

   // First acknowledge cycle shows the live winner; later cycles the frozen one.
   assign cur_idx_o = (ack_i && ack_q) ? held_idx : live_idx_i;

endmodule

// File: rtl/irqv_vec_pack.sv
module irqv_vec_pack #(
   parameter int unsigned IDX_W     = 3,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned VEC_SHIFT = 3
) (
   input  logic [IDX_W-1:0]           idx_i,
   output logic [irqv_pkg::OPC_W-1:0] opcode_o,
   output logic [ADDR_W-1:0]          addr_o
);
   import irqv_pkg::*;

   logic [FIELD_W-1:0] fld;

   assign fld      = FIELD_W'(idx_i);
   assign opcode_o = pack_restart(fld);
   assign addr_o   = ADDR_W'(idx_i) << VEC_SHIFT;

endmodule

// File: rtl/irq_restart_encoder.sv
module irq_restart_encoder #(
   parameter int unsigned NUM_REQ   = 8,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned VEC_SHIFT = 3,
   parameter int unsigned ENC_ARCH  = 0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_REQ-1:0]           req_i,
   input  logic                         ack_i,
   output logic                         intr_o,
   output logic                         valid_o,
   output logic [$clog2(NUM_REQ)-1:0]   sel_idx_o,
   output logic [ADDR_W-1:0]            call_addr_o,
   output logic                         bus_oe_o,
   output logic [irqv_pkg::OPC_W-1:0]   bus_data_o
);
   import irqv_pkg::*;

   localparam int unsigned IDX_W = $clog2(NUM_REQ);

   initial begin
      if (NUM_REQ < 2 || NUM_REQ > (1 << FIELD_W) || (1 << IDX_W) != NUM_REQ)
         $fatal(1, "NUM_REQ must be a power of two between 2 and %0d", 1 << FIELD_W);
      if (ADDR_W < IDX_W + VEC_SHIFT)
         $fatal(1, "ADDR_W too narrow for index and vector shift");
      if (ENC_ARCH != ENC_SCAN && ENC_ARCH != ENC_ONEHOT)
         $fatal(1, "unknown ENC_ARCH %0d", ENC_ARCH);
   end

   logic [IDX_W-1:0] live_idx;
   logic             any_req;
   logic [IDX_W-1:0] cur_idx;
   logic [OPC_W-1:0] opcode;
   logic [ADDR_W-1:0] vec_addr;

   irqv_prio_enc #(
      .NUM_REQ (NUM_REQ),
      .IDX_W   (IDX_W),
      .ENC_ARCH(ENC_ARCH)
   ) u_enc (
      .req_i(req_i),
      .idx_o(live_idx),
      .any_o(any_req)
   );

   irqv_ack_hold #(
      .IDX_W(IDX_W)
   ) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .ack_i     (ack_i),
      .live_idx_i(live_idx),
      .cur_idx_o (cur_idx)
   );

   irqv_vec_pack #(
      .IDX_W    (IDX_W),
      .ADDR_W   (ADDR_W),
      .VEC_SHIFT(VEC_SHIFT)
   ) u_pack (
      .idx_i   (cur_idx),
      .opcode_o(opcode),
      .addr_o  (vec_addr)
   );

   assign intr_o      = any_req & ~ack_i;
   assign valid_o     = any_req;
   assign sel_idx_o   = cur_idx;
   assign call_addr_o = vec_addr;
   assign bus_oe_o    = ack_i;
   assign bus_data_o  = ack_i ? opcode : '0;

endmodule

// File: rtl/irq_restart_encoder_chk.sv
module irq_restart_encoder_chk #(
   parameter int unsigned NUM_REQ   = 8,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned VEC_SHIFT = 3
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NUM_REQ-1:0]         req_i,
   input logic                       ack_i,
   input logic                       intr_o,
   input logic                       valid_o,
   input logic [$clog2(NUM_REQ)-1:0] sel_idx_o,
   input logic [ADDR_W-1:0]          call_addr_o,
   input logic                       bus_oe_o,
   input logic [7:0]                 bus_data_o
);

   // R1
   winner_is_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_i && valid_o) |-> req_i[sel_idx_o]);

   // R1
   none_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_i |-> (((req_i >> sel_idx_o) >> 1) == '0));

   // R3
   intr_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_i && (req_i != '0)) |-> intr_o);

   // R4
   intr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |-> !intr_o);

   // R5
   bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_i |-> (!bus_oe_o && bus_data_o == 8'h00));

   // R6
   opcode_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe_o |-> (bus_data_o[7:6] == 2'b11 && bus_data_o[2:0] == 3'b111
                    && bus_data_o[5:3] == 3'(sel_idx_o)));

   // R7
   addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      call_addr_o == (ADDR_W'(sel_idx_o) << VEC_SHIFT));

   // R8
   opcode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && $past(ack_i)) |-> ($stable(bus_data_o) && $stable(sel_idx_o)));

   // R2
   valid_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o == (req_i != '0));

endmodule

bind irq_restart_encoder irq_restart_encoder_chk #(
   .NUM_REQ  (NUM_REQ),
   .ADDR_W   (ADDR_W),
   .VEC_SHIFT(VEC_SHIFT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_i      (req_i),
   .ack_i      (ack_i),
   .intr_o     (intr_o),
   .valid_o    (valid_o),
   .sel_idx_o  (sel_idx_o),
   .call_addr_o(call_addr_o),
   .bus_oe_o   (bus_oe_o),
   .bus_data_o (bus_data_o)
);

// File: tb/sim_irq_restart_encoder.sv
module sim_irq_restart_encoder;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYC = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  req = 8'h00;
   logic        ack = 1'b0;
   logic        intr, valid, oe;
   logic [2:0]  sel;
   logic [15:0] addr;
   logic [7:0]  data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   irq_restart_encoder u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req),
      .ack_i      (ack),
      .intr_o     (intr),
      .valid_o    (valid),
      .sel_idx_o  (sel),
      .call_addr_o(addr),
      .bus_oe_o   (oe),
      .bus_data_o (data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int top_bit(input int p);
      int e = 0;
      int v = p;
      while (v > 1) begin
         v = v >> 1;
         e++;
      end
      return e;
   endfunction

   function automatic int opc_of(input int idx);
      return 32'hC7 | (idx * 8);
   endfunction

   initial begin
      int e;
      repeat (3) @(negedge clk);
      #1;
      // R10 reset state
      chk("R10 intr", int'(intr), 0);
      chk("R10 valid", int'(valid), 0);
      chk("R10 oe", int'(oe), 0);
      chk("R10 sel", int'(sel), 0);
      chk("R10 addr", int'(addr), 0);
      chk("R10 data", int'(data), 0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int p = 0; p < 256; p++) begin
         e = top_bit(p);
         @(negedge clk);
         req = 8'(p);
         ack = 1'b0;
         #1;
         chk("R1 idle sel", int'(sel), e);
         chk("R2 valid", int'(valid), (p != 0) ? 1 : 0);
         chk("R3 intr", int'(intr), (p != 0) ? 1 : 0);
         chk("R5 idle oe", int'(oe), 0);
         chk("R5 idle data", int'(data), 0);
         chk("R7 idle addr", int'(addr), e * 8);

         @(negedge clk);
         ack = 1'b1;
         #1;
         chk("R4 intr during ack", int'(intr), 0);
         chk("R5 oe during ack", int'(oe), 1);
         chk("R6 opcode", int'(data), opc_of(e));

         @(negedge clk);
         req = 8'hFF;
         #1;
         chk("R8 held opcode", int'(data), opc_of(e));
         chk("R8 held sel", int'(sel), e);
         chk("R7 held addr", int'(addr), e * 8);
         chk("R4 intr late req", int'(intr), 0);

         @(negedge clk);
         ack = 1'b0;
         #1;
         chk("R9 live sel after release", int'(sel), 7);
         chk("R9 intr after release", int'(intr), 1);
         chk("R5 data after release", int'(data), 0);
      end

      // R8 requests vanish mid-acknowledge
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         req = 8'(1 << k);
         ack = 1'b1;
         @(negedge clk);
         req = 8'h00;
         #1;
         chk("R8 hold after clear", int'(data), opc_of(k));
         chk("R2 valid after clear", int'(valid), 0);
         @(negedge clk);
         ack = 1'b0;
         #1;
         chk("R9 sel after clear", int'(sel), 0);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule